// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block decides when a small processor core sleeps and when it wakes. Software chooses one of three sleep flavours with a two-bit mode field, sets a sleep-enable bit and then issues a one-cycle sleep strobe. From the next cycle on, the block gates the CPU clock. Depending on the mode, it also gates the peripheral/converter clock and the main oscillator. While asleep it watches a set of wake sources, and which of them count depends on the mode.

In the converter-quiet mode the CPU alone stops, and the block fires one conversion-start request on entry so that the converter samples in a quiet supply. In the deepest mode every clock stops. Interrupt levels must then be confirmed on two successive ticks of a slow watchdog-oscillator enable before they count. The oscillator is then restarted, and the CPU clock is held off for a restart delay picked by a configuration field. Reset-class wake sources bypass the delay, because the reset sequence applies its own time-out.

Top module: `slpctl_top`

## Requirements
- R1: After reset the block is awake: cpu_clk_en, per_clk_en and osc_en are 1, and adc_start and wake_done are 0.
- R2: A sleep strobe while sleep_en is 0 has no effect: the CPU clock stays enabled.
- R3: An accepted strobe with mode 00 or mode 11 enters idle on the next cycle: cpu_clk_en is 0, and per_clk_en and osc_en are 1.
- R4: In idle, any of ext_irq_lvl, pcint_req, adc_done, gen_irq, ext_rst or an enabled wdt_rst re-enables the CPU clock on the following cycle.
- R5: Mode 01 enters converter-quiet sleep: cpu_clk_en is 0 and per_clk_en and osc_en are 1. adc_start pulses high for exactly the first sleep cycle if adc_enabled was 1 at the strobe, and stays 0 otherwise.
- R6: In converter-quiet sleep, ext_rst, enabled wdt_rst, ext_irq_lvl, pcint_req and adc_done wake the CPU on the following cycle, and gen_irq is ignored.
- R7: Mode 10 enters power-down: cpu_clk_en, per_clk_en and osc_en are all 0. adc_done, gen_irq and wdt_rst with wdt_enabled at 0 are ignored.
- R8: In power-down or during the restart delay, ext_rst or wdt_rst with wdt_enabled at 1 makes the block awake on the next cycle with no restart delay.
- R9: In power-down, ext_irq_lvl or pcint_req wakes the block only once the level has been high on two successive watchdog ticks. A pulse shorter than one tick period never wakes it.
- R10: After an interrupt wake from power-down, osc_en rises first and cpu_clk_en rises exactly N cycles later. N is 4, 64, 512 or 4096 for dly_sel codes 0, 1, 2 or 3.
- R11: wake_done is high for one cycle, exactly in the cycle in which cpu_clk_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Sleep flavour: 00/11 idle, 01 converter-quiet, 10 power-down |
| sleep_en | input | 1 | Permits the sleep strobe |
| sleep_strobe | input | 1 | One-cycle sleep request |
| adc_enabled | input | 1 | Converter enabled; qualifies the start request |
| wdt_enabled | input | 1 | Watchdog enabled; qualifies wdt_rst |
| dly_sel | input | 2 | Restart delay choice after power-down |
| ext_rst | input | 1 | External reset request |
| wdt_rst | input | 1 | Watchdog reset request |
| ext_irq_lvl | input | 1 | Level-triggered external interrupt request |
| pcint_req | input | 1 | Pin-change interrupt request |
| adc_done | input | 1 | Conversion-complete interrupt |
| gen_irq | input | 1 | Any other enabled interrupt |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral and converter clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| adc_start | output | 1 | One-cycle conversion start request |
| wake_done | output | 1 | One-cycle pulse when the CPU clock resumes |

## Verification
The assertions check, on every cycle, that wake_done coincides with a rising CPU clock enable, and that an awake core stays awake without an accepted strobe. They also check that the start request is a lone pulse made while only the CPU is gated, that a reset request always restores the CPU clock on the next cycle, and that the oscillator restarts only after a confirmed filtered wake. The per-mode wake source masks, the short-pulse rejection and the exact restart lengths for each delay code can only be shown by the bench's scenarios. The bench counts these cycles itself.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_QUIET   = 3'd2,
    ST_PDOWN   = 3'd3,
    ST_RESTART = 3'd4
  } slp_state_e;

  localparam logic [1:0] MODE_QUIET = 2'b01;
  localparam logic [1:0] MODE_PDOWN = 2'b10;

  // Sleep flavour picked by the mode field; 11 falls back to idle.
  function automatic slp_state_e mode_target(input logic [1:0] mode);
    case (mode)
      MODE_QUIET: mode_target = ST_QUIET;
      MODE_PDOWN: mode_target = ST_PDOWN;
      default:    mode_target = ST_IDLE;
    endcase
  endfunction

  // Restart length in cycles for a delay code.
  function automatic int unsigned restart_len(input logic [1:0] sel,
                                              input int unsigned d0, input int unsigned d1,
                                              input int unsigned d2, input int unsigned d3);
    case (sel)
      2'd0:    restart_len = d0;
      2'd1:    restart_len = d1;
      2'd2:    restart_len = d2;
      default: restart_len = d3;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    max4 = m;
  endfunction
endpackage

// File: rtl/slp_wdt_tick.sv
module slp_wdt_tick #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter #(
  parameter int unsigned SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  input  logic lvl,
  output logic qual
);
  logic [SAMPLES-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (!arm)    hist_q <= '0;
    else if (tick)    hist_q <= {hist_q[SAMPLES-2:0], lvl};
  end

  assign qual = &hist_q;
endmodule

// File: rtl/slp_restart_timer.sv
module slp_restart_timer #(
  parameter int unsigned D0 = 4,
  parameter int unsigned D1 = 64,
  parameter int unsigned D2 = 512,
  parameter int unsigned D3 = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] sel,
  input  logic       active,
  output logic       done
);
  import slp_pkg::*;
  localparam int unsigned DMAX = max4(D0, D1, D2, D3);
  localparam int unsigned CW   = $clog2(DMAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] start_val;

  assign start_val = CW'(restart_len(sel, D0, D1, D2, D3) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= start_val;
    else if (active && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = active && (cnt_q == '0);
endmodule

// File: rtl/slpctl_top.sv
module slpctl_top #(
  parameter int unsigned WDT_DIV = 16,
  parameter int unsigned DLY0    = 4,
  parameter int unsigned DLY1    = 64,
  parameter int unsigned DLY2    = 512,
  parameter int unsigned DLY3    = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       sleep_en,
  input  logic       sleep_strobe,
  input  logic       adc_enabled,
  input  logic       wdt_enabled,
  input  logic [1:0] dly_sel,
  input  logic       ext_rst,
  input  logic       wdt_rst,
  input  logic       ext_irq_lvl,
  input  logic       pcint_req,
  input  logic       adc_done,
  input  logic       gen_irq,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       adc_start,
  output logic       wake_done
);
  import slp_pkg::*;

  slp_state_e state_q, state_d;

  // Named internal events
  logic tick;
  logic rst_wake;
  logic irq_lvl;
  logic pd_qual;
  logic tmr_load;
  logic tmr_done;
  logic enter_sleep;

  assign rst_wake    = ext_rst | (wdt_rst & wdt_enabled);
  assign irq_lvl     = ext_irq_lvl | pcint_req;
  assign enter_sleep = (state_q == ST_RUN) && sleep_strobe && sleep_en;

  slp_wdt_tick #(.DIV(WDT_DIV)) tick_i (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  slp_wake_filter #(.SAMPLES(2)) filt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (state_q == ST_PDOWN),
    .tick (tick),
    .lvl  (irq_lvl),
    .qual (pd_qual)
  );

  assign tmr_load = (state_q == ST_PDOWN) && !rst_wake && pd_qual;

  slp_restart_timer #(.D0(DLY0), .D1(DLY1), .D2(DLY2), .D3(DLY3)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .sel   (dly_sel),
    .active(state_q == ST_RESTART),
    .done  (tmr_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:     if (enter_sleep) state_d = mode_target(mode_sel);
      ST_IDLE:    if (rst_wake || irq_lvl || adc_done || gen_irq) state_d = ST_RUN;
      ST_QUIET:   if (rst_wake || irq_lvl || adc_done) state_d = ST_RUN;
      ST_PDOWN: begin
        if (rst_wake)     state_d = ST_RUN;
        else if (pd_qual) state_d = ST_RESTART;
      end
      ST_RESTART: if (rst_wake || tmr_done) state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      adc_start <= 1'b0;
      wake_done <= 1'b0;
    end else begin
      state_q   <= state_d;
      adc_start <= enter_sleep && (mode_sel == MODE_QUIET) && adc_enabled;
      wake_done <= (state_d == ST_RUN) && (state_q != ST_RUN);
    end
  end

  assign cpu_clk_en = (state_q == ST_RUN);
  assign per_clk_en = (state_q == ST_RUN) || (state_q == ST_IDLE) || (state_q == ST_QUIET);
  assign osc_en     = (state_q != ST_PDOWN);
endmodule

// File: rtl/slpctl_chk.sv
module slpctl_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_en,
  input logic sleep_strobe,
  input logic ext_rst,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic osc_en,
  input logic adc_start,
  input logic wake_done,
  input logic pd_qual
);
  // R11
  wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> wake_done);
  // R11
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (cpu_clk_en && !$past(cpu_clk_en)));
  // R2
  stay_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !(sleep_strobe && sleep_en)) |=> cpu_clk_en);
  // R5
  adc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (!cpu_clk_en && per_clk_en && osc_en));
  // R5
  adc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  // R8
  rst_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && ext_rst) |=> cpu_clk_en);
  // R9
  osc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(osc_en) && !cpu_clk_en) |-> $past(pd_qual));
endmodule

bind slpctl_top slpctl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_en    (sleep_en),
  .sleep_strobe(sleep_strobe),
  .ext_rst     (ext_rst),
  .cpu_clk_en  (cpu_clk_en),
  .per_clk_en  (per_clk_en),
  .osc_en      (osc_en),
  .adc_start   (adc_start),
  .wake_done   (wake_done),
  .pd_qual     (pd_qual)
);

// File: tb/slpctl_top_tb_top.sv
module slpctl_top_tb_top;
  localparam int unsigned DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic sleep_en = 1'b0, sleep_strobe = 1'b0, adc_enabled = 1'b0, wdt_enabled = 1'b0;
  logic [1:0] dly_sel = 2'b00;
  logic ext_rst = 1'b0, wdt_rst = 1'b0, ext_irq_lvl = 1'b0, pcint_req = 1'b0;
  logic adc_done = 1'b0, gen_irq = 1'b0;
  logic cpu_clk_en, per_clk_en, osc_en, adc_start, wake_done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  slpctl_top #(.WDT_DIV(DIV)) dut_i (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_delay(input int sel);
    exp_delay = 4 << (sel == 0 ? 0 : (sel == 1 ? 4 : (sel == 2 ? 7 : 10)));
  endfunction

  // Strobe with sleep enabled; returns at the negedge of the first sleep cycle.
  task automatic go_sleep(input logic [1:0] m, input logic adc_on);
    @(negedge clk);
    mode_sel = m; adc_enabled = adc_on; sleep_en = 1'b1; sleep_strobe = 1'b1;
    @(negedge clk);
    sleep_strobe = 1'b0; sleep_en = 1'b0;
  endtask

  // Pulse one source (index) for one cycle; sample at the next negedge.
  task automatic pulse_src(input int s);
    case (s)
      0: ext_irq_lvl = 1'b1; 1: pcint_req = 1'b1; 2: adc_done = 1'b1;
      3: gen_irq = 1'b1;     4: ext_rst = 1'b1;   default: wdt_rst = 1'b1;
    endcase
    @(negedge clk);
    ext_irq_lvl = 0; pcint_req = 0; adc_done = 0; gen_irq = 0; ext_rst = 0; wdt_rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 cpu", cpu_clk_en, 1); chk("R1 per", per_clk_en, 1); chk("R1 osc", osc_en, 1);
    chk("R1 adc_start", adc_start, 0); chk("R1 wake_done", wake_done, 0);

    // R2: strobe without enable, every mode
    for (int m = 0; m < 4; m++) begin
      mode_sel = 2'(m); sleep_strobe = 1'b1;
      @(negedge clk);
      sleep_strobe = 1'b0;
      chk("R2 strobe ignored", cpu_clk_en, 1);
    end

    // R3/R4: idle via 00 and 11, woken by each source
    wdt_enabled = 1'b1;
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 6; s++) begin
        go_sleep(m == 0 ? 2'b00 : 2'b11, 1'b0);
        chk("R3 idle cpu", cpu_clk_en, 0); chk("R3 idle per", per_clk_en, 1);
        chk("R3 idle osc", osc_en, 1);
        pulse_src(s);
        chk("R4 idle wake", cpu_clk_en, 1); chk("R11 wake_done", wake_done, 1);
        @(negedge clk);
        chk("R11 single", wake_done, 0);
      end
    end

    // R5: converter-quiet entry with and without converter enabled
    for (int a = 0; a < 2; a++) begin
      go_sleep(2'b01, a[0]);
      chk("R5 quiet cpu", cpu_clk_en, 0); chk("R5 quiet per", per_clk_en, 1);
      chk("R5 adc_start", adc_start, a[0]);
      @(negedge clk);
      chk("R5 adc_start once", adc_start, 0);
      // R6: gen_irq ignored
      gen_irq = 1'b1; repeat (3) @(negedge clk); gen_irq = 1'b0;
      chk("R6 gen_irq ignored", cpu_clk_en, 0);
      pulse_src(2);
      chk("R6 adc_done wake", cpu_clk_en, 1);
    end
    for (int s = 0; s < 6; s++) begin
      if (s == 3) continue;
      go_sleep(2'b01, 1'b0);
      pulse_src(s);
      chk("R6 quiet wake", cpu_clk_en, 1); chk("R11 quiet wake_done", wake_done, 1);
    end

    // R7: power-down gating and ignored sources
    go_sleep(2'b10, 1'b1);
    chk("R7 cpu", cpu_clk_en, 0); chk("R7 per", per_clk_en, 0); chk("R7 osc", osc_en, 0);
    chk("R7 no adc_start", adc_start, 0);
    wdt_enabled = 1'b0;
    adc_done = 1; gen_irq = 1; wdt_rst = 1;
    repeat (12) @(negedge clk);
    adc_done = 0; gen_irq = 0; wdt_rst = 0;
    chk("R7 ignored osc", osc_en, 0); chk("R7 ignored cpu", cpu_clk_en, 0);
    // R9: one-cycle pulses never wake
    for (int k = 0; k < 2 * DIV; k++) begin
      ext_irq_lvl = 1'b1; @(negedge clk); ext_irq_lvl = 1'b0;
      repeat (3) @(negedge clk);
    end
    chk("R9 short pulse osc", osc_en, 0);
    // R8: enabled watchdog reset wakes directly
    wdt_enabled = 1'b1;
    pulse_src(5);
    chk("R8 wdt wake cpu", cpu_clk_en, 1); chk("R8 wdt wake_done", wake_done, 1);
    go_sleep(2'b10, 1'b0);
    pulse_src(4);
    chk("R8 ext_rst wake", cpu_clk_en, 1);

    // R9/R10: filtered wake and each restart length
    for (int d = 0; d < 4; d++) begin
      int wait_n;
      int run_n;
      dly_sel = 2'(d);
      go_sleep(2'b10, 1'b0);
      if (d[0]) pcint_req = 1'b1; else ext_irq_lvl = 1'b1;
      wait_n = 0;
      while (!osc_en && wait_n < 10 * DIV) begin @(negedge clk); wait_n++; end
      chk("R9 level wakes osc", osc_en, 1);
      chk_int("R9 needs two ticks", (wait_n >= DIV + 1) ? 1 : 0, 1);
      chk("R10 cpu held", cpu_clk_en, 0);
      run_n = 0;
      while (!cpu_clk_en && run_n < 5000) begin @(negedge clk); run_n++; end
      ext_irq_lvl = 1'b0; pcint_req = 1'b0;
      chk_int("R10 restart length", run_n, exp_delay(d));
      chk("R11 after restart", wake_done, 1);
    end

    // R8: reset during restart delay skips the rest
    dly_sel = 2'd3;
    go_sleep(2'b10, 1'b0);
    ext_irq_lvl = 1'b1;
    while (!osc_en) @(negedge clk);
    ext_irq_lvl = 1'b0;
    repeat (10) @(negedge clk);
    pulse_src(4);
    chk("R8 reset in restart", cpu_clk_en, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule